// File: doc/BRIEF.md
# Eight-bit Timer/Counter with Two Compare Channels

This block is an 8-bit counter that advances on ticks from a built-in clock divider. It has two compare channels. Each channel holds a compare value and drives one waveform output. The counter runs in one of three modes:

- **Free-running:** the counter simply wraps.
- **Clear-on-match:** the counter reloads to zero after it equals compare value A.
- **Phase-correct PWM:** the counter climbs to 0xFF and then falls back to 0x00. The waveforms are symmetric and glitch-free.

Software loads the counter and the two compare values through single-cycle write strobes. It reads three sticky event flags, clears them by writing ones, and masks each interrupt request line on its own. Compare values pass through a holding register. Outside PWM mode they take effect at once. In PWM mode they are copied across only when the count reaches its top, so a pulse can never be cut short in the middle of a period.

Top module: `tmr8_cmp_pwm`

## Requirements
- R1: After reset the count is 0x00, all three flags are clear, both interrupt lines and both waveform outputs are low, the count direction is upward and both compare values are 0x00.
- R2: `clk_sel` picks the tick rate: 0 = stopped, 1 = every clock, 2 = every 8th, 3 = every 32nd, 4 = every 64th, 5 = every 128th, 6 = every 256th, 7 = every 1024th clock. With a divide of D, after leaving the stopped state the first tick falls on the D-th clock edge.
- R3: While `clk_sel` is 0 and no counter write occurs, the count holds its value.
- R4: With `mode_sel` = 0 (free-running), each tick adds one. A tick at 0xFF wraps the count to 0x00 and sets the overflow flag (flag bit 0).
- R5: With `mode_sel` = 2 (clear-on-match), a tick while the count equals compare value A returns the count to 0x00, so the period is A+1 ticks.
- R6: With `mode_sel` = 1 (phase-correct), the count rises to 0xFF and then falls to 0x00. The tick taken at 0x00 while falling moves the count to 0x01 and sets the overflow flag. Passing 0xFF does not set it.
- R7: A tick on which the count equals a channel's active compare value sets that channel's flag: bit 1 for A, bit 2 for B.
- R8: Outside phase-correct mode, a match toggles that channel's waveform. In phase-correct mode, a match while rising drives it low and a match while falling drives it high.
- R9: A compare write goes straight to the active value outside phase-correct mode. In phase-correct mode it is held, and moves to the active value only on the tick taken at count 0xFF.
- R10: Flags are sticky. A `flag_clr_wr` strobe clears each flag whose bit in `flag_clr_bits` is one. If a flag is set and cleared in the same cycle, the set wins.
- R11: Each `irq` bit is high exactly when the matching flag bit and `irq_mask` bit are both one.
- R12: A counter write takes priority over a same-cycle tick. It suppresses compare matches on the next tick only; matches on later ticks proceed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_sel | input | 3 | Tick rate select (see R2) |
| mode_sel | input | 2 | 0 free-running, 1 phase-correct PWM, 2 clear-on-match |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | 8 | Counter load value |
| cmpa_wr | input | 1 | Compare A write strobe |
| cmpb_wr | input | 1 | Compare B write strobe |
| cmp_wdata | input | 8 | Compare write value |
| flag_clr_wr | input | 1 | Flag clear strobe |
| flag_clr_bits | input | 3 | Flags to clear (one = clear) |
| irq_mask | input | 3 | Per-flag interrupt enable |
| count | output | 8 | Current counter value |
| flags | output | 3 | Bit 0 overflow, bit 1 match A, bit 2 match B |
| irq | output | 3 | Masked interrupt requests |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |

## Verification
The hardest case to reach is the deferred compare update in phase-correct mode. The bench writes a new compare value partway up the ramp. It confirms that the old value still produces the rising match. It then runs the counter over the top and back down to the ticks just above and at the new value. One edge leaves the waveform unchanged there; the next one sets it. A buffer that loaded too early or never would fail at one of those two samples. Two more cases take precise timing: a counter load that masks only one following match, and the phase-correct overflow that fires at the bottom of the ramp and not at its peak.

// File: rtl/tmr8_pkg.sv
// Shared mode encoding and flag bit positions for the 8-bit timer.
package tmr8_pkg;
    typedef enum logic [1:0] {
        MODE_FREE  = 2'd0,
        MODE_PHASE = 2'd1,
        MODE_CLEAR = 2'd2,
        MODE_RSVD  = 2'd3
    } tmr_mode_e;

    localparam int FLG_OVF  = 0;
    localparam int FLG_CMPA = 1;
    localparam int FLG_CMPB = 2;
    localparam int NUM_FLG  = 3;
    localparam int NUM_CH   = 2;
endpackage

// File: rtl/tmr8_prescale.sv
// Clock divider producing a one-cycle count tick at the selected rate.
// Assumes clk_sel codes 1..7 map to divides 1,8,32,64,128,256,1024.
// The divider is held at zero while stopped, so every restart is aligned.
module tmr8_prescale #(
    parameter int DIV_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] clk_sel,
    output logic       tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] tap_mask;
    int               tap_bits;

    // Divider chain: free-runs while any rate is selected.
    always_ff @(posedge clk) begin
        if (!rst_n || clk_sel == 3'd0) div_q <= '0;
        else                           div_q <= div_q + 1'b1;
    end

    // Pick how many low divider bits must be all ones for a tick.
    always_comb begin
        case (clk_sel)
            3'd2:    tap_bits = 3;
            3'd3:    tap_bits = 5;
            3'd4:    tap_bits = 6;
            3'd5:    tap_bits = 7;
            3'd6:    tap_bits = 8;
            3'd7:    tap_bits = DIV_W;
            default: tap_bits = 0;
        endcase
        for (int i = 0; i < DIV_W; i++) tap_mask[i] = (i < tap_bits);
    end

    // Tick decode.
    assign tick = (clk_sel != 3'd0) && ((div_q & tap_mask) == tap_mask);
endmodule

// File: rtl/tmr8_counter.sv
// Counter core: free-running, clear-on-match and up/down phase-correct
// counting. A software load wins over a tick and arms a one-tick match block.
module tmr8_counter
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  tmr_mode_e        mode,
    input  logic [CNT_W-1:0] clr_val,
    input  logic             ld_wr,
    input  logic [CNT_W-1:0] ld_data,
    output logic [CNT_W-1:0] count,
    output logic             down,
    output logic             blk,
    output logic             ovf_evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_nxt;
    logic             down_nxt;
    logic             ovf_cond;

    // Next count, next direction and overflow condition per mode.
    always_comb begin
        cnt_nxt  = count + 1'b1;
        down_nxt = 1'b0;
        ovf_cond = (count == CNT_MAX);
        case (mode)
            MODE_CLEAR: begin
                if (count == clr_val) cnt_nxt = '0;
            end
            MODE_PHASE: begin
                ovf_cond = 1'b0;
                if (!down) begin
                    if (count == CNT_MAX) begin
                        cnt_nxt  = CNT_MAX - 1'b1;
                        down_nxt = 1'b1;
                    end
                end else if (count == '0) begin
                    cnt_nxt  = {{(CNT_W-1){1'b0}}, 1'b1};
                    ovf_cond = 1'b1;
                end else begin
                    cnt_nxt  = count - 1'b1;
                    down_nxt = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // Count, direction and match-block state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            down  <= 1'b0;
            blk   <= 1'b0;
        end else if (ld_wr) begin
            count <= ld_data;
            blk   <= 1'b1;
        end else if (tick) begin
            count <= cnt_nxt;
            down  <= down_nxt;
            blk   <= 1'b0;
        end
    end

    assign ovf_evt = tick && !ld_wr && ovf_cond;
endmodule

// File: rtl/tmr8_cmp_chan.sv
// One compare channel: holding register, active compare value, match
// detect and waveform. In PWM mode the active value reloads only at top.
module tmr8_cmp_chan #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pwm,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] count,
    input  logic             down,
    input  logic             blk,
    input  logic             ld_wr,
    output logic [CNT_W-1:0] act,
    output logic             match,
    output logic             wave
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] hold_q;
    logic             top_load;

    assign top_load = pwm && tick && !ld_wr && (count == CNT_MAX);
    assign match    = tick && !ld_wr && !blk && (count == act);

    // Holding and active compare registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            act    <= '0;
        end else begin
            if (wr) hold_q <= wdata;
            if (top_load)      act <= wr ? wdata : hold_q;
            else if (wr && !pwm) act <= wdata;
        end
    end

    // Waveform: toggle outside PWM, clear rising / set falling in PWM.
    always_ff @(posedge clk) begin
        if (!rst_n)     wave <= 1'b0;
        else if (match) wave <= pwm ? down : ~wave;
    end
endmodule

// File: rtl/tmr8_cmp_pwm.sv
// Top level of the 8-bit timer: divider, counter core, two compare
// channels, sticky flags and masked interrupt requests.
// Assumes register-style strobes are one cycle wide and synchronous to clk.
module tmr8_cmp_pwm
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       clk_sel,
    input  logic [1:0]       mode_sel,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             cmpa_wr,
    input  logic             cmpb_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             flag_clr_wr,
    input  logic [2:0]       flag_clr_bits,
    input  logic [2:0]       irq_mask,
    output logic [CNT_W-1:0] count,
    output logic [2:0]       flags,
    output logic [2:0]       irq,
    output logic             wave_a,
    output logic             wave_b
);
    tmr_mode_e        mode;
    logic             tick;
    logic             down;
    logic             blk;
    logic             ovf_evt;
    logic             pwm;
    logic [CNT_W-1:0] act_cmp [NUM_CH];
    logic [NUM_CH-1:0] ch_wr;
    logic [NUM_CH-1:0] ch_match;
    logic [NUM_CH-1:0] ch_wave;
    logic [NUM_FLG-1:0] flg_set;
    logic [NUM_FLG-1:0] flg_clr;

    assign mode  = tmr_mode_e'(mode_sel);
    assign pwm   = (mode == MODE_PHASE);
    assign ch_wr = {cmpb_wr, cmpa_wr};

    tmr8_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .tick(tick)
    );

    tmr8_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
        .clr_val(act_cmp[0]), .ld_wr(cnt_wr), .ld_data(cnt_wdata),
        .count(count), .down(down), .blk(blk), .ovf_evt(ovf_evt)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        tmr8_cmp_chan #(.CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .tick(tick), .pwm(pwm),
            .wr(ch_wr[ch]), .wdata(cmp_wdata), .count(count),
            .down(down), .blk(blk), .ld_wr(cnt_wr),
            .act(act_cmp[ch]), .match(ch_match[ch]), .wave(ch_wave[ch])
        );
    end

    assign wave_a = ch_wave[0];
    assign wave_b = ch_wave[1];

    assign flg_set[FLG_OVF]  = ovf_evt;
    assign flg_set[FLG_CMPA] = ch_match[0];
    assign flg_set[FLG_CMPB] = ch_match[1];
    assign flg_clr           = flag_clr_wr ? flag_clr_bits : '0;

    // Sticky flags: write-one clear, a new event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~flg_clr) | flg_set;
    end

    assign irq = flags & irq_mask;
endmodule

// File: rtl/tmr8_cmp_pwm_chk.sv
// Property checker for tmr8_cmp_pwm, attached by bind.
module tmr8_cmp_pwm_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       clk_sel,
    input logic [1:0]       mode_sel,
    input logic             cnt_wr,
    input logic             flag_clr_wr,
    input logic [CNT_W-1:0] count,
    input logic [2:0]       flags,
    input logic             tick,
    input logic             down,
    input logic [CNT_W-1:0] act_a,
    input logic [CNT_W-1:0] act_b
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R3
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd0 && !cnt_wr) |=> $stable(count));

    // R4
    free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd0 && tick && !cnt_wr && count == CNT_MAX)
        |=> (count == '0 && flags[0]));

    // R5
    clear_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd2 && tick && !cnt_wr && count == act_a)
        |=> (count == '0));

    // R6
    phase_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd1 && tick && !cnt_wr && down && count == '0)
        |=> (count == 1 && flags[0]));

    // R9
    pwm_glitch_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd1 && !(tick && !cnt_wr && count == CNT_MAX))
        |=> ($stable(act_a) && $stable(act_b)));

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_clr_wr |=> ((flags & $past(flags)) == $past(flags)));
endmodule

bind tmr8_cmp_pwm tmr8_cmp_pwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .mode_sel(mode_sel),
    .cnt_wr(cnt_wr), .flag_clr_wr(flag_clr_wr), .count(count),
    .flags(flags), .tick(tick), .down(down),
    .act_a(act_cmp[0]), .act_b(act_cmp[1])
);

// File: tb/tmr8_cmp_pwm_tb_top.sv
`timescale 1ns/1ps
module tmr8_cmp_pwm_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] clk_sel = '0;
    logic [1:0] mode_sel = '0;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic       cmpa_wr = 1'b0;
    logic       cmpb_wr = 1'b0;
    logic [7:0] cmp_wdata = '0;
    logic       flag_clr_wr = 1'b0;
    logic [2:0] flag_clr_bits = '0;
    logic [2:0] irq_mask = '0;
    logic [7:0] count;
    logic [2:0] flags;
    logic [2:0] irq;
    logic       wave_a;
    logic       wave_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tmr8_cmp_pwm dut_i (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .mode_sel(mode_sel),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cmpa_wr(cmpa_wr),
        .cmpb_wr(cmpb_wr), .cmp_wdata(cmp_wdata), .flag_clr_wr(flag_clr_wr),
        .flag_clr_bits(flag_clr_bits), .irq_mask(irq_mask), .count(count),
        .flags(flags), .irq(irq), .wave_a(wave_a), .wave_b(wave_b)
    );

    // mode, clk_sel, cmp A, cmp B, clocks run, expected count, flags, waves {b,a}
    typedef struct packed {
        logic [1:0]  mode;
        logic [2:0]  sel;
        logic [7:0]  ca;
        logic [7:0]  cb;
        logic [15:0] ncyc;
        logic [7:0]  ecnt;
        logic [2:0]  eflg;
        logic [1:0]  ewav;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 3'd1, 8'd200, 8'd100, 16'd10,  8'd10,  3'b000, 2'b00},
        '{2'd0, 3'd1, 8'd5,   8'd7,   16'd10,  8'd10,  3'b110, 2'b11},
        '{2'd0, 3'd1, 8'd200, 8'd100, 16'd256, 8'd0,   3'b111, 2'b11},
        '{2'd2, 3'd1, 8'd9,   8'd3,   16'd25,  8'd5,   3'b110, 2'b10},
        '{2'd2, 3'd2, 8'd4,   8'd50,  16'd100, 8'd2,   3'b010, 2'b00},
        '{2'd1, 3'd1, 8'd128, 8'd64,  16'd450, 8'd60,  3'b110, 2'b11},
        '{2'd1, 3'd1, 8'd128, 8'd64,  16'd520, 8'd10,  3'b111, 2'b11},
        '{2'd0, 3'd0, 8'd200, 8'd100, 16'd50,  8'd0,   3'b000, 2'b00},
        '{2'd0, 3'd3, 8'd3,   8'd100, 16'd200, 8'd6,   3'b010, 2'b01}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; clk_sel = 3'd0; mode_sel = 2'd0;
        cyc(2);
        rst_n = 1'b1;
    endtask

    task automatic wr_cmp(input bit chb, input logic [7:0] v);
        cmp_wdata = v;
        if (chb) cmpb_wr = 1'b1; else cmpa_wr = 1'b1;
        cyc(1);
        cmpa_wr = 1'b0; cmpb_wr = 1'b0;
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        cnt_wdata = v; cnt_wr = 1'b1;
        cyc(1);
        cnt_wr = 1'b0;
    endtask

    task automatic run(input logic [2:0] sel, input int n);
        clk_sel = sel;
        cyc(n);
        clk_sel = 3'd0;
    endtask

    // Watchdog: an expired run counts as a failure and still summarises.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        irq_mask = 3'b111;
        // R1: reset state
        do_reset();
        chk("R1 count", count, 0);
        chk("R1 flags", flags, 0);
        chk("R1 irq", irq, 0);
        chk("R1 waves", {wave_b, wave_a}, 0);

        // Table walk: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            wr_cmp(1'b0, VECS[i].ca);
            wr_cmp(1'b1, VECS[i].cb);
            mode_sel = VECS[i].mode;
            run(VECS[i].sel, int'(VECS[i].ncyc));
            chk($sformatf("R2/R4/R5/R6 vec%0d count", i), count, VECS[i].ecnt);
            chk($sformatf("R7 vec%0d flags", i), flags, VECS[i].eflg);
            chk($sformatf("R8 vec%0d waves", i), {wave_b, wave_a}, VECS[i].ewav);
        end

        // R10 R11: masking and write-one clear
        do_reset();
        wr_cmp(1'b0, 8'd5);
        wr_cmp(1'b1, 8'd7);
        run(3'd1, 10);
        irq_mask = 3'b010;
        #1;
        chk("R11 masked irq", irq, 3'b010);
        flag_clr_bits = 3'b010; flag_clr_wr = 1'b1;
        cyc(1);
        flag_clr_wr = 1'b0;
        chk("R10 write-one clear", flags, 3'b100);
        chk("R11 irq after clear", irq, 3'b000);
        irq_mask = 3'b111;
        #1;
        chk("R11 full mask", irq, 3'b100);

        // R12: load blocks only the next tick's match
        do_reset();
        wr_cmp(1'b0, 8'd5);
        wr_cmp(1'b1, 8'd200);
        wr_cnt(8'd5);
        run(3'd1, 1);
        chk("R12 count after blocked tick", count, 6);
        chk("R12 match suppressed", flags, 3'b000);
        wr_cnt(8'd4);
        run(3'd1, 2);
        chk("R12 count", count, 6);
        chk("R12 later match proceeds", flags, 3'b010);
        clk_sel = 3'd1; cnt_wdata = 8'd40; cnt_wr = 1'b1;
        cyc(1);
        cnt_wr = 1'b0; clk_sel = 3'd0;
        chk("R12 load beats tick", count, 40);

        // R9: deferred compare update in phase-correct mode
        do_reset();
        wr_cmp(1'b0, 8'd10);
        wr_cmp(1'b1, 8'd200);
        mode_sel = 2'd1;
        run(3'd1, 5);
        wr_cmp(1'b0, 8'd3);
        run(3'd1, 10);
        chk("R9 old value still matches", flags[1], 1);
        chk("R9 rising match low", wave_a, 0);
        run(3'd1, 491);
        chk("R9 count near bottom", count, 4);
        chk("R9 old value gone after top", wave_a, 0);
        run(3'd1, 2);
        chk("R9 new value sets falling", wave_a, 1);

        // R2: coarse divides, first tick on the D-th edge
        for (int s = 4; s <= 7; s++) begin
            int d;
            d = (s == 4) ? 64 : (s == 5) ? 128 : (s == 6) ? 256 : 1024;
            do_reset();
            wr_cmp(1'b0, 8'd200);
            clk_sel = 3'(s);
            cyc(d - 1);
            chk($sformatf("R2 sel%0d before tick", s), count, 0);
            cyc(1);
            clk_sel = 3'd0;
            chk($sformatf("R2 sel%0d first tick", s), count, 1);
        end

        // R3: stopped timer holds a loaded value
        do_reset();
        wr_cnt(8'd77);
        cyc(20);
        chk("R3 hold while stopped", count, 77);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule